// File: doc/BRIEF.md
# Descriptor Ring DMA Controller

This block runs two rings of buffer descriptors, a receive ring and a transmit ring, held in a small on-chip descriptor store. Software reads and writes that store, and a handful of control registers, through one word-wide register port. Each descriptor has three words: a command word, an upper status word and a buffer address word. Bit 31 of the command word is the ownership flag. Software sets it to hand a descriptor to the engine, and the engine clears it once it has finished with that descriptor.

For receive, a stub packet source offers a frame as a byte count together with an error flag. If the descriptor at the receive index belongs to the engine and receive credit remains, the engine writes the completion record back and moves on. Otherwise it drops the frame and counts the drop. For transmit, software fills descriptors and writes a kick index one past the last one filled. The engine hands each byte count to a stub sink and publishes a completion index. Two status pins report receive writebacks and an empty transmit ring.

Top module: `drc_top`

## Requirements
- R1: After reset the following are all zero: the receive index (register 8), receive credit (register 0), drop count (register 7), transmit kick (register 1), completion index (register 2) and every descriptor word. After reset `tx_empty` is 1 and `rx_ready` is 0.
- R2: `rx_ready` is 1 only while bit 0 of the receive DMA register (3) and bit 0 of the receive MAC register (4) are both set. A frame offered while `rx_ready` is 0 changes no state.
- R3: A frame is taken when it is accepted while the current receive descriptor has bit 31 of its command word set and the credit is nonzero. The engine then writes the command word with bit 31 clear, the frame length in bits 27:16 and all other bits 0. It writes the upper word with the error flag in bit 30 and all other bits 0. The address word is left unchanged. The index advances, the credit drops by one, and `rx_done` is 1 for exactly the next cycle.
- R4: A frame that is accepted while bit 31 is clear or the credit is 0 is dropped. The descriptor and the index stay unchanged, `rx_done` stays 0, and the drop count rises by one, saturating at its maximum.
- R5: A write to register 0 loads the receive credit. Values above 32 load as 32. Reading register 0 returns the credit that remains.
- R6: The transmit side is enabled when bit 0 of the transmit DMA register (5) and bit 0 of the transmit MAC register (6) are both set. While it is enabled, the completion index differs from the kick index, and the descriptor at the completion index has bit 31 set, `tx_valid` is 1. At the same time `tx_len` shows command bits 11:0 and `tx_sop` shows command bit 30.
- R7: Each `tx_valid`/`tx_ready` handshake clears bit 31 of that descriptor's command word and keeps its other bits. It also advances the completion index by one, modulo 4.
- R8: A descriptor at the completion index with bit 31 clear stalls the transmit side. `tx_valid` stays 0 and the completion index holds.
- R9: `tx_empty` is 1 exactly when the completion index equals the kick index.
- R10: Addresses with bit 8 clear reach descriptor d, word w at address 4*d+w. Descriptors 0 to 31 are the receive ring and 32 to 35 are the transmit ring. Word 0 is the command word, word 1 the upper word and word 2 the address word, and word 3 reads 0. Reads are combinational.
- R11: The receive index wraps from 31 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Register port write strobe |
| sw_addr | input | 9 | Register port word address |
| sw_wdata | input | 32 | Register port write data |
| sw_rdata | output | 32 | Register port read data (combinational) |
| rx_valid | input | 1 | Source offers a frame |
| rx_len | input | 12 | Offered frame byte count, CRC included |
| rx_err | input | 1 | Offered frame had an error |
| rx_ready | output | 1 | Receive side accepts an offer |
| tx_valid | output | 1 | A transmit byte count is presented |
| tx_len | output | 12 | Transmit byte count |
| tx_sop | output | 1 | Start-of-packet flag of that descriptor |
| tx_ready | input | 1 | Sink takes the byte count |
| rx_done | output | 1 | One-cycle pulse after a receive writeback |
| tx_empty | output | 1 | Completion index equals kick index |

## Verification
The assertions assume the following about the inputs:
- Reset is asserted from time zero.
- Receive lengths never exceed 2048.
- Software does not write a receive descriptor in the same cycle the engine writes it back.

The bench keeps within these limits in the following ways:
- It drives every input on the falling edge.
- It offers each frame as a single-cycle `rx_valid` pulse and raises `tx_ready` for one cycle at a time.
- It performs all descriptor setup before it offers a frame.

// File: rtl/drc_pkg.sv
package drc_pkg;
    localparam int unsigned RX_RING    = 32;
    localparam int unsigned TX_RING    = 4;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 9;
    localparam int unsigned LEN_W      = 12;
    localparam int unsigned DROP_W     = 16;
    localparam int unsigned OWN_BIT    = 31;
    localparam int unsigned SOP_BIT    = 30;
    localparam int unsigned ERR_BIT    = 30;
    localparam int unsigned RX_LEN_LSB = 16;

    localparam logic [3:0] REG_RX_CREDIT = 4'd0;
    localparam logic [3:0] REG_TX_KICK   = 4'd1;
    localparam logic [3:0] REG_TX_DONE   = 4'd2;
    localparam logic [3:0] REG_RX_DMA    = 4'd3;
    localparam logic [3:0] REG_RX_MAC    = 4'd4;
    localparam logic [3:0] REG_TX_DMA    = 4'd5;
    localparam logic [3:0] REG_TX_MAC    = 4'd6;
    localparam logic [3:0] REG_RX_DROPS  = 4'd7;
    localparam logic [3:0] REG_RX_INDEX  = 4'd8;

    typedef struct packed {
        logic rx_dma;
        logic rx_mac;
        logic tx_dma;
        logic tx_mac;
    } cfg_t;
endpackage

// File: rtl/drc_desc_mem.sv
module drc_desc_mem
    import drc_pkg::*;
#(
    parameter int unsigned RX_N = RX_RING,
    parameter int unsigned TX_N = TX_RING,
    localparam int unsigned D    = RX_N + TX_N,
    localparam int unsigned DIW  = $clog2(D),
    localparam int unsigned RIW  = $clog2(RX_N),
    localparam int unsigned TIW  = $clog2(TX_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_we,
    input  logic [ADDR_W-4:0]   sw_idx,
    input  logic [1:0]          sw_word,
    input  logic [DATA_W-1:0]   sw_wdata,
    output logic [DATA_W-1:0]   sw_rdata,
    input  logic [RIW-1:0]      rx_idx,
    input  logic                rx_wb_en,
    input  logic [DATA_W-1:0]   rx_cmd_w,
    input  logic [DATA_W-1:0]   rx_hi_w,
    output logic                rx_own,
    input  logic [TIW-1:0]      tx_idx,
    input  logic                tx_clr_en,
    output logic                tx_own,
    output logic                tx_sop,
    output logic [LEN_W-1:0]    tx_len
);
    logic [DATA_W-1:0] cmd_q [D];
    logic [DATA_W-1:0] hi_q  [D];
    logic [DATA_W-1:0] adr_q [D];
    logic [DATA_W-1:0] cmd_d [D];
    logic [DATA_W-1:0] hi_d  [D];
    logic [DATA_W-1:0] adr_d [D];

    logic           sw_hit;
    logic [DIW-1:0] sw_i, rx_i, tx_i;

    assign sw_hit = (32'(sw_idx) < D);
    assign sw_i   = DIW'(sw_idx);
    assign rx_i   = DIW'(rx_idx);
    assign tx_i   = DIW'(RX_N) + DIW'(tx_idx);

    always_comb begin
        cmd_d = cmd_q;
        hi_d  = hi_q;
        adr_d = adr_q;
        if (sw_we && sw_hit) begin
            case (sw_word)
                2'd0:    cmd_d[sw_i] = sw_wdata;
                2'd1:    hi_d[sw_i]  = sw_wdata;
                2'd2:    adr_d[sw_i] = sw_wdata;
                default: ;
            endcase
        end
        // engine updates are applied last so they win a same-cycle clash
        if (rx_wb_en) begin
            cmd_d[rx_i] = rx_cmd_w;
            hi_d[rx_i]  = rx_hi_w;
        end
        if (tx_clr_en) cmd_d[tx_i][OWN_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin
                cmd_q[i] <= '0;
                hi_q[i]  <= '0;
                adr_q[i] <= '0;
            end
        end else begin
            cmd_q <= cmd_d;
            hi_q  <= hi_d;
            adr_q <= adr_d;
        end
    end

    always_comb begin
        sw_rdata = '0;
        if (sw_hit) begin
            case (sw_word)
                2'd0:    sw_rdata = cmd_q[sw_i];
                2'd1:    sw_rdata = hi_q[sw_i];
                2'd2:    sw_rdata = adr_q[sw_i];
                default: sw_rdata = '0;
            endcase
        end
    end

    assign rx_own = cmd_q[rx_i][OWN_BIT];
    assign tx_own = cmd_q[tx_i][OWN_BIT];
    assign tx_sop = cmd_q[tx_i][SOP_BIT];
    assign tx_len = cmd_q[tx_i][LEN_W-1:0];
endmodule

// File: rtl/drc_rx_engine.sv
module drc_rx_engine
    import drc_pkg::*;
#(
    parameter int unsigned N  = RX_RING,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned CW = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              credit_we,
    input  logic [DATA_W-1:0] credit_wdata,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_err,
    output logic              rx_ready,
    input  logic              own_in,
    output logic [IW-1:0]     ptr,
    output logic [CW-1:0]     credit,
    output logic [DROP_W-1:0] drops,
    output logic              done,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_cmd,
    output logic [DATA_W-1:0] wb_hi
);
    typedef struct packed {
        logic [IW-1:0]     ptr;
        logic [CW-1:0]     credit;
        logic [DROP_W-1:0] drops;
        logic              done;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   accept, take;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = rx_valid && en;
        take      = accept && own_in && (st_q.credit != '0);
        if (take) begin
            st_d.ptr    = (st_q.ptr == IW'(N - 1)) ? '0 : st_q.ptr + 1'b1;
            st_d.credit = st_q.credit - 1'b1;
            st_d.done   = 1'b1;
        end else if (accept && (st_q.drops != '1)) begin
            st_d.drops = st_q.drops + 1'b1;
        end
        if (credit_we)
            st_d.credit = (credit_wdata > DATA_W'(N)) ? CW'(N) : CW'(credit_wdata);
        wb_cmd = '0;
        wb_cmd[RX_LEN_LSB +: LEN_W] = rx_len;
        wb_hi = '0;
        wb_hi[ERR_BIT] = rx_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_ready = en;
    assign wb_en    = take;
    assign ptr      = st_q.ptr;
    assign credit   = st_q.credit;
    assign drops    = st_q.drops;
    assign done     = st_q.done;

    assert_done_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(rx_valid && en && own_in));

    assert_index_moves_only_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ptr != $past(st_q.ptr)) |-> st_q.done);

    assert_drop_needs_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drops != $past(st_q.drops)) |-> ($past(rx_valid && en) && !st_q.done));
endmodule

// File: rtl/drc_tx_engine.sv
module drc_tx_engine
    import drc_pkg::*;
#(
    parameter int unsigned N  = TX_RING,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              kick_we,
    input  logic [DATA_W-1:0] kick_wdata,
    input  logic              own_in,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              clr_en,
    output logic [IW-1:0]     comp,
    output logic [IW-1:0]     kick,
    output logic              tx_empty
);
    typedef struct packed {
        logic [IW-1:0] kick;
        logic [IW-1:0] comp;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   fire;

    always_comb begin
        st_d     = st_q;
        tx_valid = en && (st_q.comp != st_q.kick) && own_in;
        fire     = tx_valid && tx_ready;
        if (fire) st_d.comp = (st_q.comp == IW'(N - 1)) ? '0 : st_q.comp + 1'b1;
        if (kick_we) st_d.kick = IW'(kick_wdata % N);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_en   = fire;
    assign comp     = st_q.comp;
    assign kick     = st_q.kick;
    assign tx_empty = (st_q.comp == st_q.kick);

    assert_comp_moves_on_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.comp != $past(st_q.comp)) |-> $past(tx_valid && tx_ready));

    assert_comp_steps_by_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.comp != $past(st_q.comp)) |->
        (st_q.comp == (($past(st_q.comp) == IW'(N - 1)) ? IW'(0) : IW'($past(st_q.comp) + 1'b1))));
endmodule

// File: rtl/drc_top.sv
module drc_top
    import drc_pkg::*;
#(
    parameter int unsigned RX_N = RX_RING,
    parameter int unsigned TX_N = TX_RING,
    localparam int unsigned RIW = $clog2(RX_N),
    localparam int unsigned TIW = $clog2(TX_N),
    localparam int unsigned CW  = $clog2(RX_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_sop,
    input  logic              tx_ready,
    output logic              rx_done,
    output logic              tx_empty
);
    cfg_t cfg_d, cfg_q;

    logic              reg_sel, reg_we, mem_we;
    logic [3:0]        reg_no;
    logic [DATA_W-1:0] mem_rdata;
    logic              rx_own, tx_own, tx_clr, rx_wb_en;
    logic [DATA_W-1:0] rx_wb_cmd, rx_wb_hi;
    logic [RIW-1:0]    rx_ptr;
    logic [CW-1:0]     rx_credit;
    logic [DROP_W-1:0] rx_drops;
    logic [TIW-1:0]    tx_comp, tx_kick;

    assign reg_sel = sw_addr[ADDR_W-1] && (sw_addr[ADDR_W-2:4] == '0);
    assign reg_no  = sw_addr[3:0];
    assign reg_we  = sw_we && reg_sel;
    assign mem_we  = sw_we && !sw_addr[ADDR_W-1];

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            case (reg_no)
                REG_RX_DMA: cfg_d.rx_dma = sw_wdata[0];
                REG_RX_MAC: cfg_d.rx_mac = sw_wdata[0];
                REG_TX_DMA: cfg_d.tx_dma = sw_wdata[0];
                REG_TX_MAC: cfg_d.tx_mac = sw_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    drc_desc_mem #(.RX_N(RX_N), .TX_N(TX_N)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .sw_we(mem_we), .sw_idx(sw_addr[ADDR_W-2:2]), .sw_word(sw_addr[1:0]),
        .sw_wdata(sw_wdata), .sw_rdata(mem_rdata),
        .rx_idx(rx_ptr), .rx_wb_en(rx_wb_en), .rx_cmd_w(rx_wb_cmd), .rx_hi_w(rx_wb_hi),
        .rx_own(rx_own),
        .tx_idx(tx_comp), .tx_clr_en(tx_clr), .tx_own(tx_own), .tx_sop(tx_sop), .tx_len(tx_len)
    );

    drc_rx_engine #(.N(RX_N)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(cfg_q.rx_dma && cfg_q.rx_mac),
        .credit_we(reg_we && (reg_no == REG_RX_CREDIT)), .credit_wdata(sw_wdata),
        .rx_valid(rx_valid), .rx_len(rx_len), .rx_err(rx_err), .rx_ready(rx_ready),
        .own_in(rx_own), .ptr(rx_ptr), .credit(rx_credit), .drops(rx_drops), .done(rx_done),
        .wb_en(rx_wb_en), .wb_cmd(rx_wb_cmd), .wb_hi(rx_wb_hi)
    );

    drc_tx_engine #(.N(TX_N)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(cfg_q.tx_dma && cfg_q.tx_mac),
        .kick_we(reg_we && (reg_no == REG_TX_KICK)), .kick_wdata(sw_wdata),
        .own_in(tx_own), .tx_valid(tx_valid), .tx_ready(tx_ready), .clr_en(tx_clr),
        .comp(tx_comp), .kick(tx_kick), .tx_empty(tx_empty)
    );

    always_comb begin
        sw_rdata = mem_rdata;
        if (sw_addr[ADDR_W-1]) begin
            sw_rdata = '0;
            if (reg_sel) begin
                case (reg_no)
                    REG_RX_CREDIT: sw_rdata = DATA_W'(rx_credit);
                    REG_TX_KICK:   sw_rdata = DATA_W'(tx_kick);
                    REG_TX_DONE:   sw_rdata = DATA_W'(tx_comp);
                    REG_RX_DMA:    sw_rdata = DATA_W'(cfg_q.rx_dma);
                    REG_RX_MAC:    sw_rdata = DATA_W'(cfg_q.rx_mac);
                    REG_TX_DMA:    sw_rdata = DATA_W'(cfg_q.tx_dma);
                    REG_TX_MAC:    sw_rdata = DATA_W'(cfg_q.tx_mac);
                    REG_RX_DROPS:  sw_rdata = DATA_W'(rx_drops);
                    REG_RX_INDEX:  sw_rdata = DATA_W'(rx_ptr);
                    default:       sw_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/drc_top_tb.sv
`timescale 1ns/1ps
module drc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [8:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        rx_valid = 1'b0;
    logic [11:0] rx_len = '0;
    logic        rx_err = 1'b0;
    logic        rx_ready, tx_valid, tx_sop, rx_done, tx_empty;
    logic [11:0] tx_len;
    logic        tx_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    drc_top u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .rx_valid(rx_valid), .rx_len(rx_len), .rx_err(rx_err),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_len(tx_len), .tx_sop(tx_sop),
        .tx_ready(tx_ready), .rx_done(rx_done), .tx_empty(tx_empty)
    );

    // own[15], err[14], expected take[13], length[11:0]
    localparam logic [15:0] VEC [6] = '{16'hA040, 16'hE5EE, 16'h0064, 16'hA800, 16'hE004, 16'h4009};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        sw_addr = a;
        #1 d = sw_rdata;
    endtask

    task automatic chk_rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic offer(input logic [11:0] len, input logic err, output logic done_seen);
        @(negedge clk);
        rx_valid = 1'b1; rx_len = len; rx_err = err;
        @(negedge clk);
        rx_valid = 1'b0;
        done_seen = rx_done;
    endtask

    task automatic tx_pulse();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int          idx, credit, drops;
        logic        dn;
        logic [31:0] own_val;
        idx = 0; credit = 0; drops = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd("R1 rx index", 9'h108, 0);
        chk_rd("R1 credit", 9'h100, 0);
        chk_rd("R1 drops", 9'h107, 0);
        chk_rd("R1 kick", 9'h101, 0);
        chk_rd("R1 completion", 9'h102, 0);
        chk_rd("R1 desc word", 9'h005, 0);
        chk_rd("R1 tx desc word", 9'h08C, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_ready", rx_ready, 0);

        // R2 both enables needed
        wr(9'h103, 1);
        chk("R2 ready with dma only", rx_ready, 0);
        wr(9'h104, 1);
        chk("R2 ready with both", rx_ready, 1);

        // R5 credit clamp
        wr(9'h100, 40);
        chk_rd("R5 credit clamp", 9'h100, 32);
        credit = 32;

        // R10 word 3 reads zero even after a write
        wr(9'h003, 32'hDEAD_BEEF);
        chk_rd("R10 word3", 9'h003, 0);

        // vector walk: R3 / R4
        for (int v = 0; v < 6; v++) begin
            logic        own, err, tk;
            logic [11:0] len;
            own = VEC[v][15]; err = VEC[v][14]; tk = VEC[v][13]; len = VEC[v][11:0];
            own_val = own ? 32'h8000_0000 : 32'h0;
            wr(9'(idx*4), own_val);
            wr(9'(idx*4+1), 32'hFFFF_FFFF);
            wr(9'(idx*4+2), 32'h1000_0000 + 32'(idx*2048));
            offer(len, err, dn);
            chk(tk ? "R3 rx_done pulse" : "R4 no rx_done", dn, tk);
            if (tk) begin
                chk_rd("R3 cmd writeback", 9'(idx*4), 32'(len) << 16);
                chk_rd("R3 status writeback", 9'(idx*4+1), 32'(err) << 30);
                chk_rd("R3 addr kept", 9'(idx*4+2), 32'h1000_0000 + 32'(idx*2048));
                chk("R3 rx_done one cycle", rx_done, 0);
                idx = (idx + 1) % 32; credit--;
            end else begin
                chk_rd("R4 cmd kept", 9'(idx*4), own_val);
                chk_rd("R4 status kept", 9'(idx*4+1), 32'hFFFF_FFFF);
                drops++;
            end
            chk_rd("R3 rx index", 9'h108, 32'(idx));
            chk_rd("R4 drop count", 9'h107, 32'(drops));
        end

        // R11 wrap of the receive index; credit runs out
        while (credit > 0) begin
            wr(9'(idx*4), 32'h8000_0000);
            offer(12'd60, 1'b0, dn);
            idx = (idx + 1) % 32; credit--;
        end
        chk_rd("R11 index wrapped", 9'h108, 0);
        chk_rd("R11 last desc cmd", 9'h07C, 32'(12'd60) << 16);
        chk_rd("R5 credit exhausted", 9'h100, 0);

        // R4 zero credit drops even an owned descriptor
        wr(9'h000, 32'h8000_0000);
        offer(12'd80, 1'b0, dn);
        drops++;
        chk("R4 credit zero no done", dn, 0);
        chk_rd("R4 credit zero cmd kept", 9'h000, 32'h8000_0000);
        chk_rd("R4 credit zero drops", 9'h107, 32'(drops));

        wr(9'h100, 5);
        chk_rd("R5 credit reload", 9'h100, 5);

        // R2 halt: offer ignored
        wr(9'h104, 0);
        chk("R2 halted ready", rx_ready, 0);
        offer(12'd90, 1'b0, dn);
        chk("R2 halted no done", dn, 0);
        chk_rd("R2 halted drops", 9'h107, 32'(drops));
        chk_rd("R2 halted index", 9'h108, 0);
        chk_rd("R2 halted cmd", 9'h000, 32'h8000_0000);

        // transmit
        wr(9'h080, 32'hC000_003C);
        wr(9'h084, 32'h8000_05EA);
        wr(9'h088, 32'h0000_004D);
        wr(9'h105, 1);
        wr(9'h106, 1);
        chk("R9 empty before kick", tx_empty, 1);
        chk("R6 no valid before kick", tx_valid, 0);
        wr(9'h101, 2);
        chk("R6 valid", tx_valid, 1);
        chk("R6 len", 32'(tx_len), 60);
        chk("R6 sop", tx_sop, 1);
        chk("R9 not empty", tx_empty, 0);
        tx_pulse();
        chk_rd("R7 completion 1", 9'h102, 1);
        chk_rd("R7 own cleared", 9'h080, 32'h4000_003C);
        chk("R6 second len", 32'(tx_len), 1514);
        chk("R6 second sop", tx_sop, 0);
        tx_pulse();
        chk_rd("R7 completion 2", 9'h102, 2);
        chk("R9 empty at kick", tx_empty, 1);
        chk("R6 no valid when empty", tx_valid, 0);

        // R8 stall on unowned descriptor
        wr(9'h101, 3);
        chk("R8 stall valid", tx_valid, 0);
        tx_pulse();
        chk_rd("R8 completion held", 9'h102, 2);
        chk("R9 not empty stalled", tx_empty, 0);
        wr(9'h088, 32'h8000_004D);
        chk("R8 released valid", tx_valid, 1);
        chk("R8 released len", 32'(tx_len), 77);
        tx_pulse();
        chk_rd("R7 completion 3", 9'h102, 3);

        // R7 wrap of completion index
        wr(9'h08C, 32'h8000_0005);
        wr(9'h101, 0);
        chk("R6 valid last slot", tx_valid, 1);
        tx_pulse();
        chk_rd("R7 completion wrap", 9'h102, 0);
        chk("R9 empty after wrap", tx_empty, 1);

        // R6 disabled transmit side
        wr(9'h080, 32'h8000_0010);
        wr(9'h105, 0);
        wr(9'h101, 1);
        chk("R6 disabled valid", tx_valid, 0);
        tx_pulse();
        chk_rd("R6 disabled completion", 9'h102, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule